// File: doc/BRIEF.md
# Programmable Clock Output Divider Bank

This block sits after a high-frequency source clock and derives two divided clocks from it, called A and B. A has two copies. One is a differential-style output, and the other is a single-ended pad output with its own output-enable. B also has two copies, B0 and B1, and both come from the same divider. Each divider picks its ratio from a pair of three-level strap inputs. A strap can be driven low, driven high or left open. Each strap is modelled as a level bit plus a separate "open" flag.

A bypass input, active low, forces both dividers to divide by one. A synchronous reset restarts both counters together, so that A and B leave reset phase-aligned. The ratio and bypass settings are captured only while reset is high, which keeps the output clean if a strap moves while the block is running.

Each output has its own enable. The enable is resynchronised to the source clock. It is applied on a falling source edge while that output is low, so that enabling or disabling an output never produces a shortened pulse. Odd ratios keep a 50% duty cycle because the output is stretched by half a source period with a falling-edge copy of the rising-edge phase.

Top module: `clkdiv_bank`

## Requirements
- R1: Each divider decodes its strap pair (strap 1, strap 0), where each strap is {open flag, level} and the level is ignored when open is 1. The codes map as follows: low-low /2, low-high /3, high-low /4, high-high /5, high-open /6, open-high /8, low-open /10, open-low /12, open-open /1.
- R2: For an even ratio N, the output period is N source cycles and the output is high for exactly N/2 of them.
- R3: For an odd ratio N greater than 1, the output period is N source cycles and the high time is N/2 cycles (N half-periods). For ratio 1 the output follows the source clock: one half-period high and one half-period low.
- R4: With bypass_n low when reset is applied, both dividers run at ratio 1, whatever their straps say.
- R5: Strap and bypass changes made while rst is low leave the running ratio unchanged. The value present during the last reset is the one in use.
- R6: While rst is high, all clock outputs and out_ac_oe are 0. After reset, every rising edge of the slower divider falls on a rising edge of the faster one when one ratio is a multiple of the other.
- R7: When an enable is held low, the matching differential output (out_a, out_b0 or out_b1) stays at 0.
- R8: With en_ac low, out_ac_oe is 0 (the pad is released to high impedance) and out_ac is 0. With en_ac high, out_ac_oe is 1 and out_ac carries divider A.
- R9: out_b0 and out_b1 are identical when both are enabled. Disabling one of them does not disturb the other.
- R10: An enable change takes effect only while the output is low, so the first pulse after enabling has the full high time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_src | input | 1 | High-frequency source clock |
| rst | input | 1 | Synchronous active-high reset; realigns both dividers and captures the straps |
| bypass_n | input | 1 | Active-low bypass; low forces ratio 1 on both dividers |
| sel_a_lvl | input | 2 | Level bits of divider A straps [1]=strap 1, [0]=strap 0 |
| sel_a_open | input | 2 | Open flags of divider A straps |
| sel_b_lvl | input | 2 | Level bits of divider B straps |
| sel_b_open | input | 2 | Open flags of divider B straps |
| en_a | input | 1 | Enable of differential output A |
| en_ac | input | 1 | Enable of single-ended output A |
| en_b0 | input | 1 | Enable of output B0 |
| en_b1 | input | 1 | Enable of output B1 |
| out_a | output | 1 | Differential-path clock from divider A |
| out_ac | output | 1 | Single-ended data from divider A |
| out_ac_oe | output | 1 | Pad drive enable for out_ac; 0 means high impedance |
| out_b0 | output | 1 | Clock from divider B, copy 0 |
| out_b1 | output | 1 | Clock from divider B, copy 1 |

## Verification
The assertions assume that rst, the straps, bypass_n and the enables are all synchronous to clk_src and change away from its edges. They also assume that an enable which has been low or high for twenty source cycles has passed through both the synchroniser and a low phase of the longest ratio. The bench drives every input on a falling edge and samples a quarter period after each edge. It holds rst for three cycles so the strap capture is clean, and it lets outputs settle for at least forty cycles before it compares them.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int RATIO_W = 4;
  typedef logic [RATIO_W-1:0] ratio_t;
  localparam ratio_t RATIO_ONE = ratio_t'(1);

  // Strap pair decode: index 1 is strap 1, index 0 is strap 0.
  function automatic ratio_t sel_decode(input logic [1:0] lvl, input logic [1:0] opn);
    ratio_t r;
    case (opn)
      2'b00: begin
        case (lvl)
          2'b00:   r = ratio_t'(2);
          2'b01:   r = ratio_t'(3);
          2'b10:   r = ratio_t'(4);
          default: r = ratio_t'(5);
        endcase
      end
      2'b01:   r = lvl[1] ? ratio_t'(6) : ratio_t'(10);
      2'b10:   r = lvl[0] ? ratio_t'(8) : ratio_t'(12);
      default: r = RATIO_ONE;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  ratio_t ratio_in,
  output logic   div_out,
  output logic   low_ok
);
  ratio_t ratio_q;
  ratio_t cnt;
  ratio_t cnt_nxt;
  ratio_t last_cnt;
  ratio_t high_thr;
  logic   ph_pos;
  logic   ph_neg;
  logic   is_one;
  logic   is_odd;

  assign is_one   = (ratio_q == RATIO_ONE);
  assign is_odd   = ratio_q[0] && !is_one;
  assign last_cnt = ratio_q - RATIO_ONE;
  assign high_thr = is_one ? RATIO_ONE : (ratio_q >> 1);

  always_comb begin
    if (cnt == last_cnt) cnt_nxt = '0;
    else                 cnt_nxt = cnt + RATIO_ONE;
  end

  // Rising-edge phase; ratio captured only while reset is high.
  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q <= ratio_in;
      cnt     <= ratio_in - RATIO_ONE;
      ph_pos  <= 1'b0;
    end else begin
      cnt    <= cnt_nxt;
      ph_pos <= (cnt_nxt < high_thr);
    end
  end

  // Half-period delayed copy for odd stretching and ratio 1.
  always_ff @(negedge clk) begin
    if (rst) ph_neg <= 1'b0;
    else     ph_neg <= ph_pos;
  end

  always_comb begin
    if (is_one)      div_out = clk & ph_neg;
    else if (is_odd) div_out = ph_pos | ph_neg;
    else             div_out = ph_pos;
  end

  assign low_ok = is_one | !ph_pos;
endmodule

// File: rtl/clkdiv_gate.sv
`timescale 1ns/1ps
module clkdiv_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_async,
  input  logic low_ok,
  output logic gate_on
);
  logic [SYNC_STAGES-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], en_async};
  end

  // Gate updates on a falling edge while the divided clock is low.
  always_ff @(negedge clk) begin
    if (rst)         gate_on <= 1'b0;
    else if (low_ok) gate_on <= sync_q[SYNC_STAGES-1];
  end
endmodule

// File: rtl/clkdiv_bank.sv
`timescale 1ns/1ps
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_src,
  input  logic       rst,
  input  logic       bypass_n,
  input  logic [1:0] sel_a_lvl,
  input  logic [1:0] sel_a_open,
  input  logic [1:0] sel_b_lvl,
  input  logic [1:0] sel_b_open,
  input  logic       en_a,
  input  logic       en_ac,
  input  logic       en_b0,
  input  logic       en_b1,
  output logic       out_a,
  output logic       out_ac,
  output logic       out_ac_oe,
  output logic       out_b0,
  output logic       out_b1
);
  localparam int N_OUT = 4;   // a, ac, b0, b1

  ratio_t ratio_a_sel;
  ratio_t ratio_b_sel;
  logic   div_a, div_b;
  logic   low_a, low_b;
  logic [N_OUT-1:0] en_vec;
  logic [N_OUT-1:0] div_vec;
  logic [N_OUT-1:0] low_vec;
  logic [N_OUT-1:0] gate_w;
  logic [N_OUT-1:0] out_vec;

  assign ratio_a_sel = bypass_n ? sel_decode(sel_a_lvl, sel_a_open) : RATIO_ONE;
  assign ratio_b_sel = bypass_n ? sel_decode(sel_b_lvl, sel_b_open) : RATIO_ONE;

  clkdiv_core u_div_a (
    .clk(clk_src), .rst(rst), .ratio_in(ratio_a_sel), .div_out(div_a), .low_ok(low_a)
  );
  clkdiv_core u_div_b (
    .clk(clk_src), .rst(rst), .ratio_in(ratio_b_sel), .div_out(div_b), .low_ok(low_b)
  );

  assign en_vec = {en_b1, en_b0, en_ac, en_a};

  for (genvar gi = 0; gi < N_OUT; gi++) begin : g_out
    if (gi < 2) begin : g_src_a
      assign div_vec[gi] = div_a;
      assign low_vec[gi] = low_a;
    end else begin : g_src_b
      assign div_vec[gi] = div_b;
      assign low_vec[gi] = low_b;
    end
    clkdiv_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk(clk_src), .rst(rst), .en_async(en_vec[gi]),
      .low_ok(low_vec[gi]), .gate_on(gate_w[gi])
    );
  end

  assign out_vec   = div_vec & gate_w;
  assign out_a     = out_vec[0];
  assign out_ac    = out_vec[1];
  assign out_ac_oe = gate_w[1];
  assign out_b0    = out_vec[2];
  assign out_b1    = out_vec[3];
endmodule

// File: rtl/clkdiv_bank_chk.sv
`timescale 1ns/1ps
module clkdiv_bank_chk #(
  parameter int SETTLE = 20
) (
  input logic clk_src,
  input logic rst,
  input logic en_a,
  input logic en_ac,
  input logic en_b0,
  input logic en_b1,
  input logic out_a,
  input logic out_ac_oe,
  input logic out_b0,
  input logic out_b1
);
  localparam int CW = $clog2(SETTLE + 1) + 1;
  logic [CW-1:0] off_a_cnt, off_ac_cnt, off_b0_cnt, both_b_cnt;

  always_ff @(posedge clk_src) begin
    if (rst) begin
      off_a_cnt  <= '0;
      off_ac_cnt <= '0;
      off_b0_cnt <= '0;
      both_b_cnt <= '0;
    end else begin
      off_a_cnt  <= en_a  ? '0 : ((off_a_cnt  >= CW'(SETTLE)) ? off_a_cnt  : off_a_cnt  + 1'b1);
      off_ac_cnt <= en_ac ? '0 : ((off_ac_cnt >= CW'(SETTLE)) ? off_ac_cnt : off_ac_cnt + 1'b1);
      off_b0_cnt <= en_b0 ? '0 : ((off_b0_cnt >= CW'(SETTLE)) ? off_b0_cnt : off_b0_cnt + 1'b1);
      both_b_cnt <= !(en_b0 && en_b1) ? '0 :
                    ((both_b_cnt >= CW'(SETTLE)) ? both_b_cnt : both_b_cnt + 1'b1);
    end
  end

  assert_reset_quiet_R6: assert property (@(posedge clk_src)
    rst |=> (!out_a && !out_b0 && !out_b1 && !out_ac_oe));

  assert_a_off_low_R7: assert property (@(posedge clk_src) disable iff (rst)
    (off_a_cnt >= CW'(SETTLE)) |-> !out_a);

  assert_b0_off_low_R7: assert property (@(posedge clk_src) disable iff (rst)
    (off_b0_cnt >= CW'(SETTLE)) |-> !out_b0);

  assert_ac_released_R8: assert property (@(posedge clk_src) disable iff (rst)
    (off_ac_cnt >= CW'(SETTLE)) |-> !out_ac_oe);

  assert_b_copies_match_R9: assert property (@(posedge clk_src) disable iff (rst)
    (both_b_cnt >= CW'(SETTLE)) |-> (out_b0 == out_b1));
endmodule

bind clkdiv_bank clkdiv_bank_chk u_chk (
  .clk_src(clk_src), .rst(rst), .en_a(en_a), .en_ac(en_ac), .en_b0(en_b0), .en_b1(en_b1),
  .out_a(out_a), .out_ac_oe(out_ac_oe), .out_b0(out_b0), .out_b1(out_b1)
);

// File: tb/clkdiv_bank_bench.sv
`timescale 1ns/1ps
module clkdiv_bank_bench;
  logic clk_src = 1'b0;
  logic rst = 1'b1;
  logic bypass_n = 1'b1;
  logic [1:0] sel_a_lvl = 2'b00, sel_a_open = 2'b00;
  logic [1:0] sel_b_lvl = 2'b00, sel_b_open = 2'b00;
  logic en_a = 1'b1, en_ac = 1'b1, en_b0 = 1'b1, en_b1 = 1'b1;
  logic out_a, out_ac, out_ac_oe, out_b0, out_b1;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk_src = ~clk_src;   // 50 MHz

  clkdiv_bank u_clkdiv_bank (
    .clk_src(clk_src), .rst(rst), .bypass_n(bypass_n),
    .sel_a_lvl(sel_a_lvl), .sel_a_open(sel_a_open),
    .sel_b_lvl(sel_b_lvl), .sel_b_open(sel_b_open),
    .en_a(en_a), .en_ac(en_ac), .en_b0(en_b0), .en_b1(en_b1),
    .out_a(out_a), .out_ac(out_ac), .out_ac_oe(out_ac_oe),
    .out_b0(out_b0), .out_b1(out_b1)
  );

  // {strap level[1:0], strap open[1:0], expected ratio[3:0]}
  localparam logic [7:0] VEC [9] = '{
    {2'b00, 2'b00, 4'd2}, {2'b01, 2'b00, 4'd3}, {2'b10, 2'b00, 4'd4},
    {2'b11, 2'b00, 4'd5}, {2'b10, 2'b01, 4'd6}, {2'b01, 2'b10, 4'd8},
    {2'b00, 2'b01, 4'd10}, {2'b00, 2'b10, 4'd12}, {2'b00, 2'b11, 4'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic pick(input int idx);
    case (idx)
      0: return out_a;
      1: return out_ac;
      2: return out_b0;
      default: return out_b1;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk_src); rst = 1'b1;
    repeat (3) @(negedge clk_src);
    rst = 1'b0;
  endtask

  // Samples at quarter periods; results in half-periods.
  task automatic measure(input int idx, output int per, output int hi);
    int k;
    @(posedge clk_src); #5;
    k = 0; while (pick(idx) == 1'b1 && k < 200) begin #10; k++; end
    k = 0; while (pick(idx) == 1'b0 && k < 200) begin #10; k++; end
    hi = 0; while (pick(idx) == 1'b1 && hi < 200) begin #10; hi++; end
    per = hi; while (pick(idx) == 1'b0 && per < 400) begin #10; per++; end
  endtask

  task automatic count_high(input int idx, input int halves, output int highs);
    highs = 0;
    @(posedge clk_src); #5;
    for (int k = 0; k < halves; k++) begin
      if (pick(idx)) highs++;
      #10;
    end
  endtask

  initial begin
    int per, hi, highs, rises, miss, diffs;
    logic pa, pb;

    // R6: outputs quiet during reset
    repeat (3) @(posedge clk_src); #5;
    check(!out_a && !out_ac && !out_b0 && !out_b1, "R6 reset outputs low",
          {out_a, out_ac, out_b0, out_b1}, 0);
    check(!out_ac_oe, "R6 reset oe low", out_ac_oe, 0);

    // R1 R2 R3: table walk over every strap code
    for (int i = 0; i < 9; i++) begin
      int j, ra, rb;
      j = (i + 4) % 9;
      ra = VEC[i][3:0];
      rb = VEC[j][3:0];
      @(negedge clk_src);
      sel_a_lvl = VEC[i][7:6]; sel_a_open = VEC[i][5:4];
      sel_b_lvl = VEC[j][7:6]; sel_b_open = VEC[j][5:4];
      do_reset();
      repeat (40) @(posedge clk_src);
      measure(0, per, hi);
      check(per == 2 * ra, (ra % 2 == 1) ? "R1 R3 A period" : "R1 R2 A period", per, 2 * ra);
      check(hi == ra, (ra % 2 == 1) ? "R3 A high time" : "R2 A high time", hi, ra);
      measure(2, per, hi);
      check(per == 2 * rb, "R1 B0 period", per, 2 * rb);
      check(hi == rb, (rb % 2 == 1) ? "R3 B0 high time" : "R2 B0 high time", hi, rb);
    end

    // R5: strap change without reset is ignored; A=/3, B=/4
    @(negedge clk_src);
    sel_a_lvl = 2'b01; sel_a_open = 2'b00;
    sel_b_lvl = 2'b10; sel_b_open = 2'b00;
    do_reset();
    repeat (40) @(posedge clk_src);
    @(negedge clk_src);
    sel_a_lvl = 2'b00; sel_a_open = 2'b10;   // would be /12
    bypass_n = 1'b0;
    repeat (40) @(posedge clk_src);
    measure(0, per, hi);
    check(per == 6, "R5 strap change ignored A period", per, 6);
    measure(2, per, hi);
    check(per == 8, "R5 bypass change ignored B period", per, 8);

    // R4: bypass captured at reset forces /1 on both (A straps /12, B /4)
    do_reset();
    repeat (40) @(posedge clk_src);
    measure(0, per, hi);
    check(per == 2 && hi == 1, "R4 bypass A ratio 1 period", per, 2);
    measure(2, per, hi);
    check(per == 2 && hi == 1, "R4 bypass B ratio 1 period", per, 2);
    @(negedge clk_src); bypass_n = 1'b1;

    // R6: alignment after reset for A=/3 B=/6 and A=/2 B=/12
    for (int c = 0; c < 2; c++) begin
      @(negedge clk_src);
      if (c == 0) begin
        sel_a_lvl = 2'b01; sel_a_open = 2'b00; sel_b_lvl = 2'b10; sel_b_open = 2'b01;
      end else begin
        sel_a_lvl = 2'b00; sel_a_open = 2'b00; sel_b_lvl = 2'b00; sel_b_open = 2'b10;
      end
      do_reset();
      repeat (40) @(posedge clk_src);
      @(posedge clk_src); #5;
      pa = out_a; pb = out_b0; rises = 0; miss = 0;
      for (int k = 0; k < 120; k++) begin
        #10;
        if (out_b0 && !pb) begin
          rises++;
          if (!(out_a && !pa)) miss++;
        end
        pa = out_a; pb = out_b0;
      end
      check(miss == 0, "R6 A/B rising edges aligned", miss, 0);
      check(rises > 0, "R6 B rising edges seen", rises, 1);
    end

    // R7 R10: A=/5, disable then re-enable
    @(negedge clk_src);
    sel_a_lvl = 2'b11; sel_a_open = 2'b00;
    do_reset();
    repeat (20) @(posedge clk_src);
    @(negedge clk_src); en_a = 1'b0;
    repeat (40) @(posedge clk_src);
    count_high(0, 60, highs);
    check(highs == 0, "R7 disabled out_a stays low", highs, 0);
    @(negedge clk_src); en_a = 1'b1;
    measure(0, per, hi);
    check(hi == 5, "R10 first pulse after enable full width", hi, 5);
    check(per == 10, "R10 period after enable", per, 10);

    // R8: single-ended path release and drive
    @(negedge clk_src); en_ac = 1'b0;
    repeat (40) @(posedge clk_src); #5;
    check(!out_ac_oe, "R8 oe low when disabled", out_ac_oe, 0);
    count_high(1, 60, highs);
    check(highs == 0, "R8 out_ac low when released", highs, 0);
    @(negedge clk_src); en_ac = 1'b1;
    repeat (40) @(posedge clk_src); #5;
    check(out_ac_oe, "R8 oe high when enabled", out_ac_oe, 1);
    measure(1, per, hi);
    check(per == 10 && hi == 5, "R8 out_ac carries divider A", per, 10);

    // R9: B copies identical, then independent disable (B=/12)
    @(posedge clk_src); #5;
    diffs = 0;
    for (int k = 0; k < 60; k++) begin
      if (out_b0 != out_b1) diffs++;
      #10;
    end
    check(diffs == 0, "R9 out_b0 equals out_b1", diffs, 0);
    @(negedge clk_src); en_b0 = 1'b0;
    repeat (40) @(posedge clk_src);
    count_high(2, 60, highs);
    check(highs == 0, "R7 R9 disabled out_b0 low", highs, 0);
    measure(3, per, hi);
    check(per == 24 && hi == 12, "R9 out_b1 undisturbed", per, 24);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #3000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule